// File: doc/BRIEF.md
# I2C Slave Controller with Clock Stretching

This block is the target side of a two-wire serial bus. It oversamples SCL and SDA with the system clock and detects START and STOP conditions. It keeps a bus-busy flag and collects the 7-bit target address that follows each START. When that address equals the programmed own address, the block acknowledges it and records the transfer direction. It then holds SCL low until the host side services the data register. The host either loads a byte to send or does a dummy read to accept incoming bytes.

One interrupt output has three causes: an address match, the end of a data byte in either direction, and a bus timeout. The host tells them apart from the address-matched and timeout status flags. The pins are open-drain and are modelled as two drive-low enables. The bench and the surrounding logic form the wired-AND of the bus.

Top module: `i2c_slv`

## Requirements
- R1: A falling SDA while SCL is high (START) sets `busy_o`. A rising SDA while SCL is high (STOP) clears `busy_o` and `addr_match_o` and returns the block to idle.
- R2: The first 7 bits after START are taken MSB first and compared with the own address. On a match the block drives SDA low during the 9th clock. On a mismatch it never drives SDA or SCL and raises no interrupt.
- R3: The 8th bit after START is latched into `rw_o`. A 1 means the master reads, so the block transmits. A 0 means the master writes, so the block receives.
- R4: `addr_match_o` is set on an address match. It is cleared when a data byte completes, on START, on STOP and on timeout.
- R5: An internal pending flag is set by an address match (at the end of the acknowledge clock), by a completed data byte, or by a timeout. `irq_o` shows the pending flag only while `irq_en_i` is 1. `irq_clr_i` clears the pending flag.
- R6: After the acknowledge clock of a matched address, `scl_low_o` holds SCL low. It releases SCL after `tx_we_i` when `rw_o`=1, or after `rx_re_i` when `rw_o`=0. The same hold follows every data byte that the master acknowledges or that the block receives.
- R7: In receive mode each byte is shifted in MSB first, acknowledged with SDA low on the 9th clock, and presented on `rx_data_o` once complete.
- R8: In transmit mode `tx_data_i` is driven MSB first, with SDA changed only while SCL is low. The master's 9th bit is stored in `rx_nack_o` (1 = NACK). After a NACK the block releases SDA and SCL and stays idle until the next START.
- R9: While `en_i` is 0 the block drives neither line, keeps `busy_o` at 0 and acknowledges no address.
- R10: The own address register loads `own_addr_i` only on a cycle where `addr_we_i`=1, `en_i`=1 and `irq_en_i`=0.
- R11: Every SCL edge reloads a counter with `tout_limit_i`. If the bus is busy and that many system clocks pass with no SCL edge, the block sets `tout_o`, raises the interrupt, releases both lines and clears `busy_o`. `tout_o` is cleared by `irq_clr_i` or by START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Block enable |
| irq_en_i | input | 1 | Interrupt enable (0 = masked) |
| addr_we_i | input | 1 | Own address write strobe |
| own_addr_i | input | 7 | Own address value |
| tout_limit_i | input | TOUT_W | Timeout length in system clocks |
| tx_we_i | input | 1 | Host write of the transmit byte |
| tx_data_i | input | 8 | Transmit byte |
| rx_re_i | input | 1 | Host read of the data register (releases the hold in receive mode) |
| irq_clr_i | input | 1 | Clear interrupt and timeout flag |
| rx_data_o | output | 8 | Last received byte |
| busy_o | output | 1 | Bus busy |
| addr_match_o | output | 1 | Address matched |
| rw_o | output | 1 | Direction bit of the current transfer |
| rx_nack_o | output | 1 | Master NACKed the last transmitted byte |
| tout_o | output | 1 | Bus timeout occurred |
| irq_o | output | 1 | Interrupt request |
| scl_i | input | 1 | SCL bus level |
| sda_i | input | 1 | SDA bus level |
| scl_low_o | output | 1 | Pull SCL low |
| sda_low_o | output | 1 | Pull SDA low |

## Verification
Some rules are checked by assertions on every cycle. The block only changes its SDA drive while SCL is low, and only starts holding SCL while the bus line is already low. A hold or an address match exists only inside a busy transfer. The direction bit stays stable through a matched transfer, a timeout frees both lines, and a disabled block is silent. The bench scenarios are needed for the rest: the address comparison and its acknowledge, the byte values moved in each direction, and the release of the hold by a host write or read. The same holds for interrupt masking, the guarded address load, the NACK ending a transmission and the timeout after an unserviced hold.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;
  localparam int unsigned ADDR_W = 7;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned BIT_CNT_W = $clog2(BYTE_W);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_RX,
    ST_RACK,
    ST_TX,
    ST_TACK,
    ST_HOLD
  } slv_state_e;
endpackage

// File: rtl/i2c_slv_sync.sv
module i2c_slv_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '1;
        else         chain_q <= line_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '1;
        else         chain_q <= {chain_q[STAGES-2:0], line_i};
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= 1'b1;
    else         last_q <= chain_q[STAGES-1];
  end

  assign lvl_o  = chain_q[STAGES-1];
  assign rise_o = lvl_o & ~last_q;
  assign fall_o = ~lvl_o & last_q;
endmodule

// File: rtl/i2c_slv_tmo.sv
module i2c_slv_tmo #(
  parameter int unsigned TOUT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              busy_i,
  input  logic              kick_i,
  input  logic [TOUT_W-1:0] limit_i,
  output logic              expire_o
);
  logic [TOUT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!busy_i || kick_i)  cnt_q <= limit_i;
    else if (cnt_q != '0)        cnt_q <= cnt_q - 1'b1;
  end

  assign expire_o = busy_i && !kick_i && (cnt_q == '0);
endmodule

// File: rtl/i2c_slv_ctl.sv
module i2c_slv_ctl
  import i2c_slv_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              sda_lvl_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              tout_i,
  input  logic              tx_we_i,
  input  logic [BYTE_W-1:0] tx_data_i,
  input  logic              rx_re_i,
  input  logic              irq_clr_i,
  output logic [BYTE_W-1:0] rx_data_o,
  output logic              busy_o,
  output logic              match_o,
  output logic              rw_o,
  output logic              nack_o,
  output logic              tout_o,
  output logic              irq_pend_o,
  output logic              scl_low_o,
  output logic              sda_low_o
);
  localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(BYTE_W - 1);

  slv_state_e           state_q;
  logic [BYTE_W-1:0]    shreg_q, rx_q;
  logic [BIT_CNT_W-1:0] cnt_q;
  logic busy_q, match_q, rw_q, nack_q, tout_q, irq_q, scl_low_q, sda_low_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      shreg_q   <= '0;
      rx_q      <= '0;
      cnt_q     <= '0;
      busy_q    <= 1'b0;
      match_q   <= 1'b0;
      rw_q      <= 1'b0;
      nack_q    <= 1'b0;
      tout_q    <= 1'b0;
      irq_q     <= 1'b0;
      scl_low_q <= 1'b0;
      sda_low_q <= 1'b0;
    end else if (!en_i) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      busy_q    <= 1'b0;
      match_q   <= 1'b0;
      nack_q    <= 1'b0;
      tout_q    <= 1'b0;
      irq_q     <= 1'b0;
      scl_low_q <= 1'b0;
      sda_low_q <= 1'b0;
    end else begin
      // SCL hold follows the state one cycle late so SDA settles first
      scl_low_q <= (state_q == ST_HOLD);
      if (irq_clr_i) begin
        irq_q  <= 1'b0;
        tout_q <= 1'b0;
      end
      if (stop_i) begin
        state_q   <= ST_IDLE;
        busy_q    <= 1'b0;
        match_q   <= 1'b0;
        sda_low_q <= 1'b0;
      end else if (start_i) begin
        state_q   <= ST_ADDR;
        busy_q    <= 1'b1;
        match_q   <= 1'b0;
        nack_q    <= 1'b0;
        tout_q    <= 1'b0;
        sda_low_q <= 1'b0;
        cnt_q     <= '0;
      end else if (tout_i) begin
        state_q   <= ST_IDLE;
        busy_q    <= 1'b0;
        match_q   <= 1'b0;
        sda_low_q <= 1'b0;
        tout_q    <= 1'b1;
        irq_q     <= 1'b1;
      end else begin
        unique case (state_q)
          ST_IDLE: ;
          ST_ADDR: if (scl_rise_i) begin
            shreg_q <= {shreg_q[BYTE_W-2:0], sda_lvl_i};
            cnt_q   <= cnt_q + 1'b1;
            if (cnt_q == LAST_BIT) begin
              cnt_q <= '0;
              if (shreg_q[ADDR_W-1:0] == own_addr_i) begin
                match_q <= 1'b1;
                rw_q    <= sda_lvl_i;
                state_q <= ST_AACK;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          ST_AACK, ST_RACK: if (scl_fall_i) begin
            if (!sda_low_q) begin
              sda_low_q <= 1'b1;
            end else begin
              sda_low_q <= 1'b0;
              irq_q     <= 1'b1;
              state_q   <= ST_HOLD;
              if (state_q == ST_RACK) match_q <= 1'b0;
            end
          end
          ST_HOLD: begin
            if (rw_q && tx_we_i) begin
              shreg_q   <= tx_data_i;
              sda_low_q <= ~tx_data_i[BYTE_W-1];
              cnt_q     <= '0;
              state_q   <= ST_TX;
            end else if (!rw_q && rx_re_i) begin
              cnt_q   <= '0;
              state_q <= ST_RX;
            end
          end
          ST_RX: if (scl_rise_i) begin
            shreg_q <= {shreg_q[BYTE_W-2:0], sda_lvl_i};
            cnt_q   <= cnt_q + 1'b1;
            if (cnt_q == LAST_BIT) begin
              rx_q    <= {shreg_q[BYTE_W-2:0], sda_lvl_i};
              cnt_q   <= '0;
              state_q <= ST_RACK;
            end
          end
          ST_TX: if (scl_fall_i) begin
            if (cnt_q == LAST_BIT) begin
              sda_low_q <= 1'b0;
              cnt_q     <= '0;
              state_q   <= ST_TACK;
            end else begin
              cnt_q     <= cnt_q + 1'b1;
              shreg_q   <= {shreg_q[BYTE_W-2:0], 1'b0};
              sda_low_q <= ~shreg_q[BYTE_W-2];
            end
          end
          ST_TACK: begin
            if (scl_rise_i) nack_q <= sda_lvl_i;
            if (scl_fall_i) begin
              irq_q   <= 1'b1;
              match_q <= 1'b0;
              state_q <= nack_q ? ST_IDLE : ST_HOLD;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign rx_data_o  = rx_q;
  assign busy_o     = busy_q;
  assign match_o    = match_q;
  assign rw_o       = rw_q;
  assign nack_o     = nack_q;
  assign tout_o     = tout_q;
  assign irq_pend_o = irq_q;
  assign scl_low_o  = scl_low_q;
  assign sda_low_o  = sda_low_q;
endmodule

// File: rtl/i2c_slv.sv
module i2c_slv
  import i2c_slv_pkg::*;
#(
  parameter int unsigned TOUT_W    = 16,
  parameter int unsigned SYNC_STGS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              irq_en_i,
  input  logic              addr_we_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic [TOUT_W-1:0] tout_limit_i,
  input  logic              tx_we_i,
  input  logic [BYTE_W-1:0] tx_data_i,
  input  logic              rx_re_i,
  input  logic              irq_clr_i,
  output logic [BYTE_W-1:0] rx_data_o,
  output logic              busy_o,
  output logic              addr_match_o,
  output logic              rw_o,
  output logic              rx_nack_o,
  output logic              tout_o,
  output logic              irq_o,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_low_o,
  output logic              sda_low_o
);
  logic [ADDR_W-1:0] own_q;
  logic scl_lvl, scl_rise, scl_fall;
  logic sda_lvl, sda_rise, sda_fall;
  logic start, stop, expire, irq_pend;

  // address only changes while enabled with interrupts masked
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             own_q <= '0;
    else if (addr_we_i && en_i && !irq_en_i) own_q <= own_addr_i;
  end

  i2c_slv_sync #(.STAGES(SYNC_STGS)) u_scl_sync (
    .clk_i, .rst_ni, .line_i(scl_i),
    .lvl_o(scl_lvl), .rise_o(scl_rise), .fall_o(scl_fall)
  );

  i2c_slv_sync #(.STAGES(SYNC_STGS)) u_sda_sync (
    .clk_i, .rst_ni, .line_i(sda_i),
    .lvl_o(sda_lvl), .rise_o(sda_rise), .fall_o(sda_fall)
  );

  assign start = sda_fall & scl_lvl & ~scl_rise;
  assign stop  = sda_rise & scl_lvl & ~scl_rise;

  i2c_slv_tmo #(.TOUT_W(TOUT_W)) u_tmo (
    .clk_i, .rst_ni,
    .busy_i   (busy_o),
    .kick_i   (scl_rise | scl_fall | start),
    .limit_i  (tout_limit_i),
    .expire_o (expire)
  );

  i2c_slv_ctl u_ctl (
    .clk_i, .rst_ni, .en_i,
    .own_addr_i (own_q),
    .sda_lvl_i  (sda_lvl),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start),
    .stop_i     (stop),
    .tout_i     (expire),
    .tx_we_i, .tx_data_i, .rx_re_i, .irq_clr_i,
    .rx_data_o,
    .busy_o,
    .match_o    (addr_match_o),
    .rw_o,
    .nack_o     (rx_nack_o),
    .tout_o,
    .irq_pend_o (irq_pend),
    .scl_low_o,
    .sda_low_o
  );

  assign irq_o = irq_pend & irq_en_i;
endmodule

// File: rtl/i2c_slv_chk.sv
module i2c_slv_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic scl_i,
  input logic busy_o,
  input logic addr_match_o,
  input logic rw_o,
  input logic tout_o,
  input logic scl_low_o,
  input logic sda_low_o
);
  AST_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!scl_low_o && !sda_low_o && !busy_o)); // R9

  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_low_o) |-> !scl_i); // R8

  AST_HOLD_IN_TRANSFER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_low_o |-> (busy_o || tout_o)); // R6

  AST_HOLD_ON_LOW_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(scl_low_o) |-> !scl_i); // R6

  AST_TOUT_FREES_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tout_o) |=> (!scl_low_o && !sda_low_o && !busy_o)); // R11

  AST_DIR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_match_o && $past(addr_match_o)) |-> $stable(rw_o)); // R3

  AST_MATCH_IN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_match_o |-> busy_o); // R4
endmodule

bind i2c_slv i2c_slv_chk u_chk (.*);

// File: tb/tb_i2c_slv.sv
module tb_i2c_slv;
  localparam int HP     = 8;
  localparam int TOUT_W = 16;
  localparam logic [15:0] TOUT_RUN = 16'd300;
  localparam logic [6:0]  OWN = 7'h5A;
  // {addr[6:0], rw, data[7:0], acked}
  localparam logic [16:0] VEC [6] = '{
    {7'h5A, 1'b0, 8'hC3, 1'b1},
    {7'h5A, 1'b1, 8'h96, 1'b1},
    {7'h5B, 1'b0, 8'h00, 1'b0},
    {7'h1A, 1'b1, 8'h00, 1'b0},
    {7'h5A, 1'b0, 8'h01, 1'b1},
    {7'h5A, 1'b1, 8'h80, 1'b1}
  };

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0, en = 1'b0, irq_en = 1'b0, addr_we = 1'b0;
  logic [6:0] own_addr = '0;
  logic [TOUT_W-1:0] tout_limit = TOUT_RUN;
  logic tx_we = 1'b0, rx_re = 1'b0, irq_clr = 1'b0;
  logic [7:0] tx_data = '0;
  logic [7:0] rx_data;
  logic busy, addr_match, rw, rx_nack, tout, irq, scl_low, sda_low;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic scl_bus, sda_bus;
  int checks = 0, errors = 0;
  logic done = 1'b0;

  assign scl_bus = scl_m & ~scl_low;
  assign sda_bus = sda_m & ~sda_low;

  i2c_slv #(.TOUT_W(TOUT_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .irq_en_i(irq_en),
    .addr_we_i(addr_we), .own_addr_i(own_addr), .tout_limit_i(tout_limit),
    .tx_we_i(tx_we), .tx_data_i(tx_data), .rx_re_i(rx_re), .irq_clr_i(irq_clr),
    .rx_data_o(rx_data), .busy_o(busy), .addr_match_o(addr_match), .rw_o(rw),
    .rx_nack_o(rx_nack), .tout_o(tout), .irq_o(irq),
    .scl_i(scl_bus), .sda_i(sda_bus), .scl_low_o(scl_low), .sda_low_o(sda_low)
  );

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic m_start();
    sda_m = 1'b0; wait_n(HP);
    scl_m = 1'b0; wait_n(HP);
  endtask

  task automatic m_stop();
    sda_m = 1'b0; wait_n(HP);
    scl_m = 1'b1;
    while (scl_bus !== 1'b1) @(negedge clk);
    wait_n(HP);
    sda_m = 1'b1; wait_n(HP);
  endtask

  task automatic m_bit(input logic b, output logic r);
    sda_m = b; wait_n(HP);
    scl_m = 1'b1;
    while (scl_bus !== 1'b1) @(negedge clk);
    wait_n(HP/2);
    r = sda_bus;
    wait_n(HP/2);
    scl_m = 1'b0; wait_n(HP);
  endtask

  task automatic m_byte(input logic [7:0] b, output logic [7:0] r);
    logic rb;
    for (int i = 7; i >= 0; i--) begin
      m_bit(b[i], rb);
      r[i] = rb;
    end
  endtask

  task automatic host_read();
    rx_re = 1'b1; wait_n(1); rx_re = 1'b0;
  endtask

  task automatic host_write(input logic [7:0] d);
    tx_data = d; tx_we = 1'b1; wait_n(1); tx_we = 1'b0;
  endtask

  task automatic irq_clear();
    irq_clr = 1'b1; wait_n(1); irq_clr = 1'b0; wait_n(1);
  endtask

  task automatic load_addr(input logic [6:0] a);
    own_addr = a; addr_we = 1'b1; wait_n(1); addr_we = 1'b0; wait_n(1);
  endtask

  // START plus address byte plus acknowledge bit; returns SDA seen on 9th clock
  task automatic addr_phase(input logic [6:0] a, input logic d, output logic ack_lvl);
    logic [7:0] dummy;
    m_start();
    m_byte({a, d}, dummy);
    m_bit(1'b1, ack_lvl);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1 act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [6:0] va;
    logic       vrw, vack, r;
    logic [7:0] vd, got;

    wait_n(4);
    rst_n = 1'b1;
    wait_n(2);
    // reset state
    chk("R1 reset busy", busy, 0);
    chk("R6 reset scl_low", scl_low, 0);
    chk("R2 reset sda_low", sda_low, 0);
    chk("R5 reset irq", irq, 0);
    chk("R11 reset tout", tout, 0);

    en = 1'b1;
    load_addr(OWN);
    irq_en = 1'b1;

    for (int k = 0; k < 6; k++) begin
      {va, vrw, vd, vack} = VEC[k];
      m_start();
      chk("R1 busy after START", busy, 1);
      m_byte({va, vrw}, got);
      m_bit(1'b1, r);
      chk("R2 ack level", r, !vack);
      if (vack) begin
        chk("R4 match flag", addr_match, 1);
        chk("R3 direction", rw, vrw);
        chk("R5 addr irq", irq, 1);
        chk("R6 hold after addr", scl_low, 1);
        irq_clear();
        chk("R5 irq cleared", irq, 0);
        if (!vrw) begin
          host_read();
          wait_n(3);
          chk("R6 released by read", scl_low, 0);
          m_byte(vd, got);
          m_bit(1'b1, r);
          chk("R7 data ack", r, 0);
          chk("R7 rx data", rx_data, vd);
          chk("R5 data irq", irq, 1);
          chk("R4 match cleared by data", addr_match, 0);
          chk("R6 hold after rx byte", scl_low, 1);
          irq_clear();
          host_read();
          wait_n(3);
        end else begin
          host_write(vd);
          m_byte(8'hFF, got);
          m_bit(1'b1, r);
          chk("R8 tx data", got, vd);
          chk("R8 nack stored", rx_nack, 1);
          chk("R8 scl free after nack", scl_low, 0);
          chk("R8 sda free after nack", sda_low, 0);
          chk("R5 tx data irq", irq, 1);
          irq_clear();
        end
      end else begin
        chk("R2 no irq on mismatch", irq, 0);
        chk("R2 no match on mismatch", addr_match, 0);
        chk("R2 no hold on mismatch", scl_low, 0);
      end
      m_stop();
      chk("R1 busy cleared by STOP", busy, 0);
      chk("R1 match cleared by STOP", addr_match, 0);
    end

    // two-byte transmit, first byte acknowledged
    addr_phase(OWN, 1'b1, r);
    chk("R2 tx addr ack", r, 0);
    irq_clear();
    host_write(8'hA5);
    m_byte(8'hFF, got);
    m_bit(1'b0, r);
    chk("R8 first tx byte", got, 8'hA5);
    chk("R8 ack stored", rx_nack, 0);
    chk("R6 hold after acked tx byte", scl_low, 1);
    chk("R5 irq after tx byte", irq, 1);
    irq_clear();
    host_write(8'h3C);
    m_byte(8'hFF, got);
    m_bit(1'b1, r);
    chk("R8 second tx byte", got, 8'h3C);
    chk("R8 final nack", rx_nack, 1);
    m_stop();
    chk("R1 busy after tx stop", busy, 0);

    // interrupt mask
    irq_en = 1'b0;
    addr_phase(OWN, 1'b0, r);
    chk("R5 masked irq", irq, 0);
    chk("R6 hold while masked", scl_low, 1);
    irq_en = 1'b1;
    wait_n(1);
    chk("R5 pending shows after unmask", irq, 1);
    irq_clear();
    host_read();
    wait_n(3);
    m_stop();

    // address load guarded by interrupt mask
    load_addr(7'h11);
    addr_phase(7'h11, 1'b0, r);
    chk("R10 load blocked while irq enabled", r, 1);
    m_stop();
    irq_en = 1'b0;
    load_addr(7'h11);
    irq_en = 1'b1;
    addr_phase(7'h11, 1'b0, r);
    chk("R10 load accepted while masked", r, 0);
    irq_clear();
    host_read();
    wait_n(3);
    m_stop();
    irq_en = 1'b0;
    load_addr(OWN);
    irq_en = 1'b1;

    // timeout during an unserviced hold
    tout_limit = 16'd40;
    addr_phase(OWN, 1'b0, r);
    chk("R6 hold before timeout", scl_low, 1);
    wait_n(70);
    chk("R11 tout flag", tout, 1);
    chk("R11 scl released", scl_low, 0);
    chk("R11 busy cleared", busy, 0);
    chk("R11 irq", irq, 1);
    irq_clear();
    chk("R11 tout cleared", tout, 0);
    m_stop();
    tout_limit = TOUT_RUN;

    // disabled block ignores the bus
    en = 1'b0;
    wait_n(2);
    addr_phase(OWN, 1'b0, r);
    chk("R9 no ack while disabled", r, 1);
    chk("R9 not busy while disabled", busy, 0);
    chk("R9 no hold while disabled", scl_low, 0);
    m_stop();
    en = 1'b1;
    wait_n(2);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule